// File: doc/BRIEF.md
# Bus Initiator Phase Sequencer

This block is the initiator end of a parallel, wired-OR peripheral bus. After a start pulse from the host it waits for the bus to be idle and contends for ownership. It then addresses one target and hands over a short command block. Finally it accepts data bytes from the target until the target lets go of the bus. The host supplies its own ID, the target ID and a buffer of command bytes. Received bytes come back on a data port qualified by a one-cycle valid strobe.

The block does not model the bus electrically. It presents a set of assertion outputs (busy claim, select, data lines, acknowledge), and it samples the resolved bus levels on separate inputs. Those inputs are the OR of every driver on the bus, this one included. The target controls a request strobe and two phase lines: a control/data line and a direction line. Together these tell the sequencer which transfer is being asked for. Each byte moves by a four-edge handshake. The request rises, the acknowledge rises, the request falls, and then the acknowledge falls.

Top module: `sq_init_seq`

## Requirements
- R1: While reset is held, every bus drive (busy claim, select, data lines, acknowledge) is low, and `rx_valid_o`, `done_o`, `sel_err_o` and `active_o` are low.
- R2: After a start, contention begins only once both resolved busy and resolved select have been low for FREE_CYC consecutive clock edges. Any busy or select activity restarts the count.
- R3: During the one contention cycle the sequencer asserts its busy claim and drives exactly one data line, the line whose index equals its own ID.
- R4: If a data line with a higher index than its own ID (line 7 ranks highest) is seen during contention, the sequencer drops all drives on the next cycle. It then waits for a fresh bus-free period of FREE_CYC edges before contending again. A lower-index line does not make it withdraw.
- R5: After winning, the sequencer drives select together with the data lines of its own ID and the target ID for one cycle with busy still claimed. From the following cycle it keeps select and both ID lines but releases busy.
- R6: When the target raises busy in answer, the sequencer releases select and all data lines on the next cycle and remains active.
- R7: If busy has not been seen after SEL_TMO cycles with busy released, the sequencer drops every drive, returns to idle and sets `sel_err_o`. The flag stays set until the next accepted start.
- R8: On a command request (strobe high, control/data high, direction low), the sequencer drives the next command byte and raises acknowledge on the next cycle. Acknowledge stays high until the strobe is seen low and falls on the cycle after that.
- R9: Command bytes go out in buffer order from byte 0. Bits 3:0 of byte 0 give how many bytes follow it, capped at CMD_MAX-1. A command request beyond that count is not acknowledged.
- R10: On a data-in request (strobe high, control/data low, direction high), the data lines are captured. On the next cycle `rx_data_o` holds the byte, `rx_valid_o` is high for exactly that one cycle, and acknowledge is raised under the same rule as R8.
- R11: While connected, a low resolved busy returns the sequencer to idle: `done_o` pulses for one cycle and `active_o` falls in that same cycle.
- R12: A request with control/data and direction both high (a phase not handled) never raises acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Host request to begin a session, taken while idle |
| own_id_i | input | ID_W | ID of this initiator |
| tgt_id_i | input | ID_W | ID of the target to address |
| cmd_buf_i | input | CMD_MAX*2**ID_W | Command bytes, byte i at bits [i*DW +: DW] |
| bus_busy_i | input | 1 | Resolved busy level on the bus |
| bus_select_i | input | 1 | Resolved select level on the bus |
| bus_dat_i | input | 2**ID_W | Resolved data lines |
| tgt_strobe_i | input | 1 | Target request strobe |
| tgt_ctl_i | input | 1 | Target phase line: high for command, low for data |
| tgt_dir_i | input | 1 | Target phase line: high when the target sends |
| busy_drv_o | output | 1 | Busy claim driven by this initiator |
| sel_drv_o | output | 1 | Select driven by this initiator |
| dat_drv_o | output | 2**ID_W | Data lines driven by this initiator |
| ack_drv_o | output | 1 | Acknowledge driven by this initiator |
| rx_data_o | output | 2**ID_W | Last byte received from the target |
| rx_valid_o | output | 1 | One-cycle strobe for `rx_data_o` |
| done_o | output | 1 | One-cycle pulse when the target releases the bus |
| sel_err_o | output | 1 | Sticky flag: the target never answered selection |
| active_o | output | 1 | High from an accepted start until return to idle |

## Verification
The bench counts the edges between the bus going quiet and the busy claim rising. A design that miscounted the free window, or kept the count running through busy activity, would contend too early or too late. It places a higher-ranked contender line on the bus to force a withdrawal, and then a lower-ranked one that must be ignored. A comparison with the wrong sense would either never win or never back off. It also issues command requests beyond the length given in byte 0 and requests in an unhandled phase. A design that acknowledged those would hang or corrupt the exchange. Finally it measures the length of the select window when no target answers. An off-by-one timer would show up as a window one cycle too short or too long.

// File: rtl/sq_pkg.sv
package sq_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_FREE, S_ARB, S_SELA, S_SELB, S_CONN, S_CACK, S_DACK
  } sq_state_e;

  // number of command bytes that follow byte 0, capped to the buffer
  function automatic int unsigned cmd_tail(input logic [3:0] nib,
                                           input int unsigned max_bytes);
    int unsigned t;
    t = {28'd0, nib};
    return (t > max_bytes - 1) ? max_bytes - 1 : t;
  endfunction

endpackage

// File: rtl/sq_window_cnt.sv
module sq_window_cnt #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic cond,
  output logic hit
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (arm && cond && !hit) cnt_q <= cnt_q + 1'b1;
    else                    cnt_q <= '0;
  end

  assign hit = arm && cond && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/sq_arb_judge.sv
module sq_arb_judge #(
  parameter int unsigned ID_W = 3,
  localparam int unsigned DW  = 1 << ID_W
) (
  input  logic [ID_W-1:0] own_id,
  input  logic [DW-1:0]   bus_dat,
  output logic            outranked
);
  logic [DW-1:0] above;

  for (genvar i = 0; i < DW; i++) begin : g_rank
    assign above[i] = bus_dat[i] && (own_id < ID_W'(i));
  end

  assign outranked = |above;
endmodule

// File: rtl/sq_cmd_pick.sv
module sq_cmd_pick
  import sq_pkg::*;
#(
  parameter int unsigned CMD_MAX = 16,
  parameter int unsigned DW      = 8,
  localparam int unsigned IW     = $clog2(CMD_MAX) + 1
) (
  input  logic [CMD_MAX*DW-1:0] cmd_buf,
  input  logic [IW-1:0]         idx,
  output logic [DW-1:0]         byte_o,
  output logic [IW-1:0]         tail_o
);
  always_comb begin
    byte_o = '0;
    for (int i = 0; i < CMD_MAX; i++) begin
      if (idx == IW'(i)) byte_o = cmd_buf[i*DW +: DW];
    end
  end

  assign tail_o = IW'(cmd_tail(cmd_buf[3:0], CMD_MAX));
endmodule

// File: rtl/sq_init_seq.sv
module sq_init_seq
  import sq_pkg::*;
#(
  parameter int unsigned ID_W     = 3,
  parameter int unsigned CMD_MAX  = 16,
  parameter int unsigned FREE_CYC = 4,
  parameter int unsigned SEL_TMO  = 20
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_i,
  input  logic [ID_W-1:0]               own_id_i,
  input  logic [ID_W-1:0]               tgt_id_i,
  input  logic [CMD_MAX*(1<<ID_W)-1:0]  cmd_buf_i,
  input  logic                          bus_busy_i,
  input  logic                          bus_select_i,
  input  logic [(1<<ID_W)-1:0]          bus_dat_i,
  input  logic                          tgt_strobe_i,
  input  logic                          tgt_ctl_i,
  input  logic                          tgt_dir_i,
  output logic                          busy_drv_o,
  output logic                          sel_drv_o,
  output logic [(1<<ID_W)-1:0]          dat_drv_o,
  output logic                          ack_drv_o,
  output logic [(1<<ID_W)-1:0]          rx_data_o,
  output logic                          rx_valid_o,
  output logic                          done_o,
  output logic                          sel_err_o,
  output logic                          active_o
);
  localparam int unsigned DW = 1 << ID_W;
  localparam int unsigned IW = $clog2(CMD_MAX) + 1;

  sq_state_e state_q, state_d;
  logic [IW-1:0] idx_q;
  logic [DW-1:0] rx_q;
  logic          rx_vld_q, done_q, err_q;

  // named internal events
  logic          bus_quiet, arb_phase, free_hit, tmo_hit, outranked;
  logic          cmd_call, din_call, cmd_left, tgt_gone;
  logic [DW-1:0] own_bit, tgt_bit, cmd_byte;
  logic [IW-1:0] tail;

  assign bus_quiet = !bus_busy_i && !bus_select_i;
  assign arb_phase = (state_q == S_ARB);
  assign cmd_call  = tgt_strobe_i && tgt_ctl_i && !tgt_dir_i;
  assign din_call  = tgt_strobe_i && !tgt_ctl_i && tgt_dir_i;
  assign tgt_gone  = !bus_busy_i;
  assign own_bit   = DW'(1) << own_id_i;
  assign tgt_bit   = DW'(1) << tgt_id_i;
  assign cmd_left  = (idx_q <= tail);

  sq_window_cnt #(.LIMIT(FREE_CYC)) u_free (
    .clk(clk), .rst_n(rst_n), .arm(state_q == S_FREE),
    .cond(bus_quiet), .hit(free_hit)
  );

  sq_window_cnt #(.LIMIT(SEL_TMO)) u_tmo (
    .clk(clk), .rst_n(rst_n), .arm(state_q == S_SELB),
    .cond(tgt_gone), .hit(tmo_hit)
  );

  sq_arb_judge #(.ID_W(ID_W)) u_judge (
    .own_id(own_id_i), .bus_dat(bus_dat_i), .outranked(outranked)
  );

  sq_cmd_pick #(.CMD_MAX(CMD_MAX), .DW(DW)) u_pick (
    .cmd_buf(cmd_buf_i), .idx(idx_q), .byte_o(cmd_byte), .tail_o(tail)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (start_i) state_d = S_FREE;
      S_FREE: if (free_hit) state_d = S_ARB;
      S_ARB:  state_d = outranked ? S_FREE : S_SELA;
      S_SELA: state_d = S_SELB;
      S_SELB: begin
        if (bus_busy_i)   state_d = S_CONN;
        else if (tmo_hit) state_d = S_IDLE;
      end
      S_CONN: begin
        if (tgt_gone)                  state_d = S_IDLE;
        else if (cmd_call && cmd_left) state_d = S_CACK;
        else if (din_call)             state_d = S_DACK;
      end
      S_CACK: if (!tgt_strobe_i) state_d = S_CONN;
      S_DACK: if (!tgt_strobe_i) state_d = S_CONN;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      idx_q    <= '0;
      rx_q     <= '0;
      rx_vld_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      rx_vld_q <= 1'b0;
      done_q   <= (state_q == S_CONN) && tgt_gone;
      if (state_q == S_IDLE && start_i) begin
        idx_q <= '0;
        err_q <= 1'b0;
      end
      if (state_q == S_CACK && !tgt_strobe_i) idx_q <= idx_q + 1'b1;
      if (state_q == S_CONN && !tgt_gone && din_call) begin
        rx_q     <= bus_dat_i;
        rx_vld_q <= 1'b1;
      end
      if (state_q == S_SELB && !bus_busy_i && tmo_hit) err_q <= 1'b1;
    end
  end

  always_comb begin
    busy_drv_o = (state_q == S_ARB) || (state_q == S_SELA);
    sel_drv_o  = (state_q == S_SELA) || (state_q == S_SELB);
    ack_drv_o  = (state_q == S_CACK) || (state_q == S_DACK);
    unique case (state_q)
      S_ARB:          dat_drv_o = own_bit;
      S_SELA, S_SELB: dat_drv_o = own_bit | tgt_bit;
      S_CACK:         dat_drv_o = cmd_byte;
      default:        dat_drv_o = '0;
    endcase
  end

  assign rx_data_o  = rx_q;
  assign rx_valid_o = rx_vld_q;
  assign done_o     = done_q;
  assign sel_err_o  = err_q;
  assign active_o   = (state_q != S_IDLE);
endmodule

// File: rtl/sq_checker.sv
module sq_checker #(
  parameter int unsigned ID_W = 3,
  localparam int unsigned DW  = 1 << ID_W
) (
  input logic            clk,
  input logic            rst_n,
  input logic            arb_phase,
  input logic            bus_quiet,
  input logic [ID_W-1:0] own_id,
  input logic            busy_drv,
  input logic            sel_drv,
  input logic [DW-1:0]   dat_drv,
  input logic            ack,
  input logic            strobe,
  input logic            ctl,
  input logic            dir,
  input logic            rx_valid,
  input logic            err
);
  // R2
  arb_after_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_phase) |-> $past(bus_quiet));

  // R3
  arb_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arb_phase |-> (busy_drv && $countones(dat_drv) == 1 && dat_drv[own_id]));

  // R5
  sel_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_drv && $past(sel_drv)) |-> !busy_drv);

  // R7
  tmo_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> (!sel_drv && !busy_drv && dat_drv == '0));

  // R8
  ack_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack) |-> $past(!strobe));

  // R10
  rx_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(strobe && !ctl && dir));

  // R12
  ack_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> $past(strobe && (ctl != dir)));
endmodule

bind sq_init_seq sq_checker #(.ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .arb_phase(arb_phase), .bus_quiet(bus_quiet),
  .own_id(own_id_i), .busy_drv(busy_drv_o), .sel_drv(sel_drv_o),
  .dat_drv(dat_drv_o), .ack(ack_drv_o), .strobe(tgt_strobe_i),
  .ctl(tgt_ctl_i), .dir(tgt_dir_i), .rx_valid(rx_valid_o), .err(sel_err_o)
);

// File: tb/sim_sq_init_seq.sv
module sim_sq_init_seq;
  localparam int ID_W = 3, CMD_MAX = 16, FREE_CYC = 4, SEL_TMO = 20;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [2:0] own_id = 3'd5, tgt_id = 3'd2;
  logic [CMD_MAX*8-1:0] cmd_buf = '0;
  logic other_busy = 1'b0, other_sel = 1'b0, tgt_busy = 1'b0;
  logic [7:0] other_dat = '0, tgt_dat = '0;
  logic strobe = 1'b0, ctl = 1'b0, dir = 1'b0;
  logic busy_drv, sel_drv, ack, rx_valid, done, err, active;
  logic [7:0] dat_drv, rx_data;
  logic bus_busy, bus_sel;
  logic [7:0] bus_dat;

  int tests = 0, fails = 0;
  logic [7:0] cmd_q[$];
  logic [7:0] data_q[$];
  logic ack_prev = 1'b0;

  assign bus_busy = busy_drv | tgt_busy | other_busy;
  assign bus_sel  = sel_drv | other_sel;
  assign bus_dat  = dat_drv | tgt_dat | other_dat;

  always #2 clk = ~clk;

  sq_init_seq #(.ID_W(ID_W), .CMD_MAX(CMD_MAX), .FREE_CYC(FREE_CYC),
                .SEL_TMO(SEL_TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .own_id_i(own_id),
    .tgt_id_i(tgt_id), .cmd_buf_i(cmd_buf), .bus_busy_i(bus_busy),
    .bus_select_i(bus_sel), .bus_dat_i(bus_dat), .tgt_strobe_i(strobe),
    .tgt_ctl_i(ctl), .tgt_dir_i(dir), .busy_drv_o(busy_drv),
    .sel_drv_o(sel_drv), .dat_drv_o(dat_drv), .ack_drv_o(ack),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .done_o(done),
    .sel_err_o(err), .active_o(active)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic nedge();
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // scoreboard monitors
  always @(negedge clk) begin
    if (ack && !ack_prev && ctl && !dir) begin
      if (cmd_q.size() == 0) chk(1'b0, "R9 unexpected cmd ack", dat_drv, 0);
      else begin
        logic [7:0] e;
        e = cmd_q.pop_front();
        chk(dat_drv == e, "R9 cmd byte", dat_drv, e);
      end
    end
    if (rx_valid) begin
      if (data_q.size() == 0) chk(1'b0, "R10 extra rx_valid", rx_data, 0);
      else begin
        logic [7:0] e;
        e = data_q.pop_front();
        chk(rx_data == e, "R10 rx byte", rx_data, e);
      end
    end
    ack_prev <= ack;
  end

  task automatic wait_ack(input string req);
    bit seen = 1'b0;
    for (int i = 0; i < 20 && !seen; i++) begin
      nedge();
      seen = ack;
    end
    chk(seen, req, 0, 1);
  endtask

  // driver: loads the buffer and pushes the bytes the target must see
  task automatic load_cmd(input logic [7:0] b[4]);
    int n;
    for (int i = 0; i < CMD_MAX; i++) cmd_buf[i*8 +: 8] = 8'hEE;
    for (int i = 0; i < 4; i++) cmd_buf[i*8 +: 8] = b[i];
    n = int'(b[0] & 8'h0F) + 1;
    for (int i = 0; i < n; i++) cmd_q.push_back(cmd_buf[i*8 +: 8]);
  endtask

  task automatic target_cmd(input int n);
    ctl = 1'b1; dir = 1'b0;
    for (int i = 0; i < n; i++) begin
      strobe = 1'b1;
      wait_ack("R8 cmd ack rise");
      strobe = 1'b0;
      nedge();
      chk(!ack, "R8 ack falls after strobe low", ack, 0);
    end
  endtask

  task automatic target_data(input logic [7:0] v);
    ctl = 1'b0; dir = 1'b1;
    tgt_dat = v;
    data_q.push_back(v);
    strobe = 1'b1;
    wait_ack("R10 data ack rise");
    strobe = 1'b0; tgt_dat = '0;
    nedge();
    chk(!ack, "R10 ack falls after strobe low", ack, 0);
  endtask

  initial begin
    #400000;
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic [7:0] cb[4];
    bit any_ack;
    int cnt;
    other_busy = 1'b1;
    repeat (3) nedge();
    // R1
    chk(!busy_drv && !sel_drv && dat_drv == 0 && !ack, "R1 drives idle", dat_drv, 0);
    chk(!rx_valid && !done && !err && !active, "R1 status idle",
        {rx_valid, done, err, active}, 0);
    rst_n = 1'b1;
    nedge();

    cb = '{8'hA3, 8'h11, 8'h22, 8'h33};
    load_cmd(cb);

    start = 1'b1; nedge(); start = 1'b0;
    repeat (6) nedge();
    chk(!busy_drv && active, "R2 no claim while bus busy", busy_drv, 0);

    // bus goes quiet, a higher-ranked contender line is present
    other_busy = 1'b0; other_dat = 8'h80;
    repeat (3) nedge();
    chk(!busy_drv, "R2 no claim before FREE_CYC", busy_drv, 0);
    nedge();
    chk(busy_drv, "R2 claim after FREE_CYC", busy_drv, 1);
    chk(dat_drv == 8'h20, "R3 own ID line only", dat_drv, 8'h20);
    nedge();
    chk(!busy_drv && !sel_drv && dat_drv == 0, "R4 withdraw on higher ID",
        dat_drv, 0);
    other_busy = 1'b1;
    repeat (5) nedge();
    chk(!busy_drv, "R4 waits while winner holds bus", busy_drv, 0);

    // fresh bus-free period; a lower-ranked contender line is present
    other_busy = 1'b0; other_dat = 8'h02;
    repeat (3) nedge();
    chk(!busy_drv, "R4 retry waits for full window", busy_drv, 0);
    nedge();
    chk(busy_drv && dat_drv == 8'h20, "R4 retry contends", dat_drv, 8'h20);
    nedge();
    other_dat = 8'h00;
    chk(sel_drv && busy_drv && dat_drv == 8'h24, "R5 select with busy",
        {sel_drv, busy_drv, dat_drv}, {2'b11, 8'h24});
    nedge();
    chk(sel_drv && !busy_drv && dat_drv == 8'h24, "R5 busy released",
        {sel_drv, busy_drv, dat_drv}, {2'b10, 8'h24});
    nedge();
    chk(sel_drv, "R5 select held awaiting target", sel_drv, 1);
    tgt_busy = 1'b1;
    nedge();
    chk(!sel_drv && dat_drv == 0 && active, "R6 release after answer",
        {sel_drv, dat_drv}, 0);

    // command phase: 1 + 3 bytes
    target_cmd(4);
    chk(cmd_q.size() == 0, "R9 all cmd bytes sent", cmd_q.size(), 0);
    // a request beyond the length must be ignored
    strobe = 1'b1;
    any_ack = 1'b0;
    repeat (4) begin nedge(); any_ack |= ack; end
    chk(!any_ack, "R9 no ack beyond length", any_ack, 0);
    strobe = 1'b0;
    nedge();

    // data-in phase
    target_data(8'h5A);
    target_data(8'hC3);
    target_data(8'h00);
    target_data(8'hFF);
    nedge();
    chk(data_q.size() == 0, "R10 all data delivered", data_q.size(), 0);

    // unhandled phase
    ctl = 1'b1; dir = 1'b1; strobe = 1'b1;
    any_ack = 1'b0;
    repeat (4) begin nedge(); any_ack |= ack; end
    chk(!any_ack, "R12 no ack in unhandled phase", any_ack, 0);
    strobe = 1'b0; ctl = 1'b0; dir = 1'b0;
    nedge();

    // target releases the bus
    tgt_busy = 1'b0;
    nedge();
    chk(done && !active, "R11 done pulse and idle", {done, active}, 2'b10);
    nedge();
    chk(!done, "R11 done lasts one cycle", done, 0);

    // selection with no target answering
    start = 1'b1; nedge(); start = 1'b0;
    cnt = 0;
    for (int i = 0; i < 60 && cnt == 0; i++) begin
      nedge();
      if (sel_drv) cnt = 1;
    end
    while (sel_drv && cnt < 100) begin
      nedge();
      if (sel_drv) cnt++;
    end
    chk(cnt == SEL_TMO + 1, "R7 select window length", cnt, SEL_TMO + 1);
    chk(err && !active, "R7 error flag set", {err, active}, 2'b10);
    chk(!busy_drv && !sel_drv && dat_drv == 0, "R7 drives dropped", dat_drv, 0);
    repeat (3) nedge();
    chk(err, "R7 flag sticky", err, 1);
    start = 1'b1; nedge(); start = 1'b0;
    chk(!err, "R7 flag cleared by start", err, 0);

    finish_run();
  end
endmodule